// File: doc/BRIEF.md
# MII Frame Transmitter

This block sends one Ethernet frame at a time onto a 4-bit media-independent transmit interface. It runs in the transmit clock domain that the PHY supplies (25 MHz for 100 Mbps, 2.5 MHz for 10 Mbps). A one-cycle start request carries a byte count. The block then emits a fixed header of seven preamble bytes (0x55) and one start-frame delimiter byte (0xD5). After the header it sends the payload, taken from an external byte buffer, one nibble per clock.

Frame lengths are checked against a packed limits word. A request longer than the maximum is refused and nothing goes out. A request shorter than the minimum is padded with zero bytes. When transmit enable drops, the block stays busy for a programmable inter-packet gap before it accepts the next request. A request can also ask for a single-cycle coding-error mark inside the frame.

Top module: `mii_frame_tx`

## Requirements
- R1: After reset, txEn, txErr, busy, done and lenErr are low and txData is 0.
- R2: An accepted frame begins with 14 nibbles of 0x5 followed by the nibbles 0x5 then 0xD. txEn rises with the first of these nibbles, one cycle after the start request is sampled.
- R3: Every byte goes out low nibble first, then high nibble. Payload byte k is read from buffer address k, and the buffer returns data one cycle after the address is presented.
- R4: txEn stays high without a gap for exactly 2*(8+L) cycles, where L is the padded payload length, and drops in the cycle after the final nibble.
- R5: The minimum length sits in lenLimits[31:16]. When byteCount is below it, zero bytes follow the real payload until L equals the minimum.
- R6: The maximum length sits in lenLimits[15:0]. A start with byteCount above it raises lenErr for exactly one cycle, sends nothing and leaves busy low. A count equal to the maximum is accepted.
- R7: When forceErr is high together with an accepted start, txErr is high for exactly one cycle, on the low nibble of the first payload byte, and never while txEn is low.
- R8: After txEn drops, busy stays high for max(gapCycles,1) cycles, where gapCycles is the value sampled at start. done pulses for one cycle in the first of those cycles.
- R9: A start request while busy is high is ignored. No extra frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY transmit clock |
| rstN | input | 1 | Synchronous active-low reset |
| startReq | input | 1 | One-cycle frame start request |
| byteCount | input | 16 | Payload bytes to send |
| forceErr | input | 1 | Request a coding-error mark with this start |
| lenLimits | input | 32 | Minimum length in [31:16], maximum length in [15:0] |
| gapCycles | input | 16 | Inter-packet gap in clock cycles |
| bufAddr | output | 16 | Payload buffer read address |
| bufData | input | 8 | Payload buffer read data, one cycle after the address |
| txEn | output | 1 | Transmit enable |
| txData | output | 4 | Transmit nibble |
| txErr | output | 1 | Transmit coding error |
| busy | output | 1 | Frame or gap in progress |
| done | output | 1 | One-cycle pulse when a frame ends |
| lenErr | output | 1 | One-cycle pulse when an oversize request is refused |

## Verification
The assertions assume that startReq is a clean pulse sampled at the clock. They also assume that the buffer behind bufAddr answers with exactly one cycle of latency, and that lenLimits and byteCount are stable while a request is sampled. The stimulus follows these assumptions. It changes inputs only on the falling edge and models the buffer as a registered lookup keyed on bufAddr. It issues each regular request only after busy has fallen. The single exception is the deliberate mid-frame request used to show that such a request is ignored.

// File: rtl/mii_tx_pkg.sv
package mii_tx_pkg;

  typedef enum logic [1:0] {
    SEL_PRE = 2'd0,
    SEL_SFD = 2'd1,
    SEL_PAY = 2'd2,
    SEL_PAD = 2'd3
  } nibSrc_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_GAP  = 2'd2
  } txState_e;

  typedef struct packed {
    logic    active;
    nibSrc_e src;
    logic    hiNib;
    logic    errNow;
  } txStrobes_t;

  localparam logic [7:0] PRE_BYTE = 8'h55;
  localparam logic [7:0] SFD_BYTE = 8'hD5;

endpackage

// File: rtl/mii_tx_ctrl.sv
module mii_tx_ctrl
  import mii_tx_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int GAP_W     = 16,
  parameter int PRE_BYTES = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic [LEN_W-1:0]   byteCount,
  input  logic               forceErr,
  input  logic [2*LEN_W-1:0] lenLimits,
  input  logic [GAP_W-1:0]   gapCycles,
  output txStrobes_t         strobes,
  output logic [LEN_W-1:0]   bufAddr,
  output logic               busy,
  output logic               done,
  output logic               lenErr
);
  localparam int IDX_W = LEN_W + 1;
  localparam logic [IDX_W-1:0] PRE_IDX = IDX_W'(PRE_BYTES);
  localparam logic [IDX_W-1:0] HDR_IDX = IDX_W'(PRE_BYTES + 1);

  txState_e         state;
  logic [IDX_W-1:0] byteIdx, lastIdx, nextIdx, payIdx;
  logic             hiNib, errArm, doneQ, lenErrQ;
  logic [LEN_W-1:0] cntLatch;
  logic [GAP_W-1:0] gapLatch, gapCnt;
  logic [LEN_W-1:0] minLen, maxLen, padLen;
  logic             tooLong, lastNib, errNow;

  assign minLen  = lenLimits[2*LEN_W-1:LEN_W];
  assign maxLen  = lenLimits[LEN_W-1:0];
  assign tooLong = byteCount > maxLen;
  assign padLen  = (byteCount < minLen) ? minLen : byteCount;
  assign lastNib = (state == ST_SEND) && hiNib && (byteIdx == lastIdx);
  assign errNow  = (state == ST_SEND) && errArm && (byteIdx == HDR_IDX) && !hiNib;
  assign payIdx  = byteIdx - HDR_IDX;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      byteIdx  <= '0;
      lastIdx  <= '0;
      hiNib    <= 1'b0;
      errArm   <= 1'b0;
      doneQ    <= 1'b0;
      lenErrQ  <= 1'b0;
      cntLatch <= '0;
      gapLatch <= '0;
      gapCnt   <= '0;
    end else begin
      doneQ   <= 1'b0;
      lenErrQ <= 1'b0;
      unique case (state)
        ST_IDLE: if (startReq) begin
          if (tooLong) begin
            lenErrQ <= 1'b1;
          end else begin
            state    <= ST_SEND;
            byteIdx  <= '0;
            hiNib    <= 1'b0;
            cntLatch <= byteCount;
            lastIdx  <= {1'b0, padLen} + HDR_IDX - IDX_W'(1);
            gapLatch <= gapCycles;
            errArm   <= forceErr;
          end
        end
        ST_SEND: begin
          hiNib <= ~hiNib;
          if (hiNib) byteIdx <= byteIdx + IDX_W'(1);
          if (errNow) errArm <= 1'b0;
          if (lastNib) begin
            state  <= ST_GAP;
            gapCnt <= '0;
            doneQ  <= 1'b1;
          end
        end
        ST_GAP: begin
          if (({1'b0, gapCnt} + (GAP_W+1)'(1)) >= {1'b0, gapLatch}) state <= ST_IDLE;
          else gapCnt <= gapCnt + GAP_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.active = (state == ST_SEND);
    strobes.hiNib  = hiNib;
    strobes.errNow = errNow;
    if (byteIdx < PRE_IDX)                 strobes.src = SEL_PRE;
    else if (byteIdx == PRE_IDX)           strobes.src = SEL_SFD;
    else if (payIdx < {1'b0, cntLatch})    strobes.src = SEL_PAY;
    else                                   strobes.src = SEL_PAD;
  end

  always_comb begin
    nextIdx = hiNib ? byteIdx + IDX_W'(1) : byteIdx;
    if (state == ST_SEND && nextIdx >= HDR_IDX) bufAddr = LEN_W'(nextIdx - HDR_IDX);
    else                                        bufAddr = '0;
  end

  assign busy   = (state != ST_IDLE);
  assign done   = doneQ;
  assign lenErr = lenErrQ;

  p_send_holds_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEND && !lastNib) |=> (state == ST_SEND));
  p_reject_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && startReq && tooLong) |=> (lenErr && !busy));
  p_lenerr_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    lenErr |-> !busy);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_after_send_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busy && $past(state) == ST_SEND));
endmodule

// File: rtl/mii_tx_dpath.sv
module mii_tx_dpath
  import mii_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  txStrobes_t strobes,
  input  logic [7:0] bufData,
  output logic       txEn,
  output logic [3:0] txData,
  output logic       txErr
);
  logic [7:0] curByte;

  always_comb begin
    unique case (strobes.src)
      SEL_PRE: curByte = PRE_BYTE;
      SEL_SFD: curByte = SFD_BYTE;
      SEL_PAY: curByte = bufData;
      default: curByte = 8'h00;
    endcase
  end

  assign txEn   = strobes.active;
  assign txData = !strobes.active ? 4'h0 : (strobes.hiNib ? curByte[7:4] : curByte[3:0]);
  assign txErr  = strobes.active && strobes.errNow;

  p_err_in_frame_r7: assert property (@(posedge clk) disable iff (!rstN)
    txErr |-> txEn);
  p_err_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    txErr |=> !txErr);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !txEn |-> (txData == 4'h0));
endmodule

// File: rtl/mii_frame_tx.sv
module mii_frame_tx
  import mii_tx_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int GAP_W     = 16,
  parameter int PRE_BYTES = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic [LEN_W-1:0]   byteCount,
  input  logic               forceErr,
  input  logic [2*LEN_W-1:0] lenLimits,
  input  logic [GAP_W-1:0]   gapCycles,
  output logic [LEN_W-1:0]   bufAddr,
  input  logic [7:0]         bufData,
  output logic               txEn,
  output logic [3:0]         txData,
  output logic               txErr,
  output logic               busy,
  output logic               done,
  output logic               lenErr
);
  txStrobes_t strobes;

  mii_tx_ctrl #(.LEN_W(LEN_W), .GAP_W(GAP_W), .PRE_BYTES(PRE_BYTES)) ctrl_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .byteCount(byteCount),
    .forceErr(forceErr), .lenLimits(lenLimits), .gapCycles(gapCycles),
    .strobes(strobes), .bufAddr(bufAddr), .busy(busy), .done(done), .lenErr(lenErr)
  );

  mii_tx_dpath dpath_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .bufData(bufData),
    .txEn(txEn), .txData(txData), .txErr(txErr)
  );

  p_en_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    txEn |-> busy);
endmodule

// File: tb/mii_frame_tx_tb.sv
module mii_frame_tx_tb_top;
  typedef struct {
    logic [3:0] nib;
    logic       err;
    string      tag;
  } expNib_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [15:0] byteCount = '0;
  logic        forceErr = 1'b0;
  logic [31:0] lenLimits = {16'd64, 16'd1536};
  logic [15:0] gapCycles = 16'd18;
  logic [15:0] bufAddr;
  logic [7:0]  bufData = '0;
  logic        txEn, txErr, busy, done, lenErr;
  logic [3:0]  txData;

  int checks = 0;
  int fails  = 0;
  expNib_t expQ[$];
  int      gapQ[$];

  always #4 clk = ~clk;

  mii_frame_tx dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .byteCount(byteCount),
    .forceErr(forceErr), .lenLimits(lenLimits), .gapCycles(gapCycles),
    .bufAddr(bufAddr), .bufData(bufData), .txEn(txEn), .txData(txData),
    .txErr(txErr), .busy(busy), .done(done), .lenErr(lenErr)
  );

  function automatic logic [7:0] byteAt(input logic [15:0] a);
    return 8'(a * 16'd37 + 16'd11);
  endfunction

  always @(posedge clk) bufData <= byteAt(bufAddr);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic pushByte(input logic [7:0] b, input bit e, input string tag);
    expQ.push_back('{nib: b[3:0], err: e, tag: tag});
    expQ.push_back('{nib: b[7:4], err: 1'b0, tag: tag});
  endtask

  task automatic sendFrame(input int cnt, input int gap, input bit err);
    int minL = int'(lenLimits[31:16]);
    int padL = (cnt < minL) ? minL : cnt;
    while (busy) @(negedge clk);
    for (int i = 0; i < 7; i++) pushByte(8'h55, 1'b0, "R2");
    pushByte(8'hD5, 1'b0, "R2");
    for (int k = 0; k < padL; k++) begin
      if (k < cnt) pushByte(byteAt(16'(k)), err && (k == 0), (k == 0) ? "R7" : "R3");
      else         pushByte(8'h00, 1'b0, "R5");
    end
    gapQ.push_back((gap == 0) ? 1 : gap);
    byteCount = 16'(cnt);
    gapCycles = 16'(gap);
    forceErr  = err;
    startReq  = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    forceErr = 1'b0;
    check(txEn == 1'b1, "R2 txEn rise", int'(txEn), 1);
    while (busy) @(negedge clk);
    @(negedge clk);
    check(expQ.size() == 0, "R4 nibble count", expQ.size(), 0);
  endtask

  // monitor: compares produced nibbles and gap length with the scoreboard
  initial begin
    logic prevEn = 1'b0;
    bit   inGap = 1'b0;
    int   gapRun = 0;
    expNib_t e;
    @(posedge rstN);
    forever begin
      @(posedge clk);
      #2;
      if (txEn) begin
        if (expQ.size() == 0) check(1'b0, "R9 unexpected nibble", int'(txData), -1);
        else begin
          e = expQ.pop_front();
          check(txData == e.nib, e.tag, int'(txData), int'(e.nib));
          check(txErr == e.err, "R7 txErr", int'(txErr), int'(e.err));
        end
      end else if (txErr) check(1'b0, "R7 txErr without txEn", 1, 0);
      if (prevEn && !txEn) begin
        check(done == 1'b1, "R8 done pulse", int'(done), 1);
        inGap  = 1'b1;
        gapRun = 0;
      end else if (done) check(1'b0, "R8 stray done", 1, 0);
      if (inGap) begin
        if (busy) gapRun++;
        else begin
          inGap = 1'b0;
          if (gapQ.size() > 0) check(gapRun == gapQ.pop_front(), "R8 gap length", gapRun, -1);
        end
      end
      prevEn = txEn;
    end
  end

  initial begin
    #(8 * 150000);
    check(1'b0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check({txEn, txErr, busy, done, lenErr} == 5'b0, "R1 reset outputs",
          int'({txEn, txErr, busy, done, lenErr}), 0);
    check(txData == 4'h0, "R1 reset data", int'(txData), 0);
    rstN = 1'b1;
    @(negedge clk);

    // default limits: 64 byte frame
    sendFrame(64, 18, 1'b0);
    // short frame padded to default minimum (R5)
    sendFrame(10, 3, 1'b0);

    // tighter limits: min 8, max 20
    lenLimits = {16'd8, 16'd20};
    sendFrame(20, 0, 1'b0);   // exactly max accepted (R6), gap 0 -> 1 (R8)
    sendFrame(8, 1, 1'b1);    // exactly min, coding error (R7)
    sendFrame(3, 5, 1'b0);    // padding (R5)

    // oversize request refused (R6)
    byteCount = 16'd21;
    startReq  = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check(lenErr == 1'b1, "R6 lenErr", int'(lenErr), 1);
    check(busy == 1'b0, "R6 busy low", int'(busy), 0);
    @(negedge clk);
    check(lenErr == 1'b0, "R6 lenErr single", int'(lenErr), 0);
    repeat (10) begin
      @(negedge clk);
      check(txEn == 1'b0, "R6 no transmit", int'(txEn), 0);
    end

    // start while busy ignored (R9)
    fork
      sendFrame(12, 4, 1'b0);
      begin
        repeat (20) @(negedge clk);
        byteCount = 16'd5;
        startReq  = 1'b1;
        @(negedge clk);
        startReq = 1'b0;
      end
    join
    repeat (30) begin
      @(negedge clk);
      check(!txEn && !busy, "R9 no extra frame", int'(txEn), 0);
    end

    finishRun();
  end
endmodule